// File: doc/BRIEF.md
# Local-to-PCI Address Window Decoder

This block sits between a local processor bus and a PCI master engine. Each local memory cycle arrives as an address with a valid strobe. The block checks that address against two programmable windows. The first window maps local addresses onto PCI memory space. The second maps them onto PCI I/O space or onto configuration cycles. The local bus only issues memory cycles, so the PCI command space depends only on which window decodes the address.

Each window has three registers. A local base gives the window's position. A range mask has ones in the compared bits and zeros in the offset bits, so the window runs from its base up to the size the mask leaves open. A remap base is the PCI start address that replaces the matched local base.

A shared mode register enables each window separately. It also chooses between I/O and configuration accesses for the second window. All registers are loaded through a simple write port. The decode result is registered and appears one cycle after the request.

Top module: `lpci_window_decoder`

## Requirements
- R1: After reset, every register is zero and both windows are disabled. With no request, `hit` is 0, `space` is 2'b00 and `pciAddr` is 0.
- R2: A request that falls in the enabled memory window gives `hit`=1 and `space`=2'b01. The translated address is `pciAddr` = (remap & range) | (addr & ~range).
- R3: A request that falls in the enabled I/O window, with the mode configuration bit at 0, gives `space`=2'b10. The address is translated with that window's own range and remap.
- R4: With the mode configuration bit at 1, an I/O-window hit gives `space`=2'b11 (configuration access) instead.
- R5: Only the address bits set in a window's range mask are compared with its base. Changing a masked-out bit keeps the hit. Changing a compared bit loses it.
- R6: When both enabled windows match the same address, the memory window is selected.
- R7: When a request matches no enabled window, or when `reqValid` is low, the next cycle shows `hit`=0, `space`=2'b00 and `pciAddr`=0.
- R8: Results appear on the clock edge that samples the request, so there is one cycle of latency. A register write takes effect for requests from the following cycle. A request in the same cycle as a write uses the old value.
- R9: `cfgSel` selects the register to write. The codes are: 0 memory base, 1 memory range, 2 memory remap, 3 I/O base, 4 I/O range, 5 I/O remap, 6 mode. The mode bits are: bit0 memory window enable, bit1 I/O window enable, bit2 configuration select. A write with code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select code |
| cfgData | input | ADDR_W | Register write data |
| reqValid | input | 1 | Local memory cycle request |
| reqAddr | input | ADDR_W | Local address of the request |
| hit | output | 1 | Request decoded into a window |
| space | output | 2 | 00 none, 01 memory, 10 I/O, 11 configuration |
| pciAddr | output | ADDR_W | Translated PCI address |

## Verification
A vector table programs overlapping windows and then sweeps the addresses that matter. It checks the first and last offsets of the memory window and the first address beyond it, which tells the inclusive bound from the exclusive one. It checks an address inside both windows under each enable setting, which separates priority from enable gating. It checks the same I/O hit with the configuration bit clear and set, which separates the two non-memory spaces.

Directed tests then shrink a range mask to show which bits are compared. They issue a write and a request in the same cycle to pin down when register updates take effect. They check a write with the unused select code and the idle-cycle clearing of the outputs.

// File: rtl/lpci_win_pkg.sv
package lpci_win_pkg;
  localparam int NWIN = 2;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_MEM_BASE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MEM_RANGE = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MEM_REMAP = 3'd2;
  localparam logic [SEL_W-1:0] SEL_IO_BASE   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_IO_RANGE  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_IO_REMAP  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_MODE      = 3'd6;

  typedef enum logic [1:0] {
    SP_NONE = 2'b00,
    SP_MEM  = 2'b01,
    SP_IO   = 2'b10,
    SP_CFG  = 2'b11
  } space_e;

  typedef struct packed {
    logic [NWIN-1:0] loadBase;
    logic [NWIN-1:0] loadRange;
    logic [NWIN-1:0] loadRemap;
    logic            loadMode;
    logic            capture;
  } strobes_t;
endpackage

// File: rtl/lpci_win_control.sv
module lpci_win_control
  import lpci_win_pkg::*;
(
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             reqValid,
  output strobes_t         st
);
  always_comb begin
    st = '0;
    st.capture = reqValid;
    if (cfgWrEn) begin
      unique case (cfgSel)
        SEL_MEM_BASE:  st.loadBase[0]  = 1'b1;
        SEL_MEM_RANGE: st.loadRange[0] = 1'b1;
        SEL_MEM_REMAP: st.loadRemap[0] = 1'b1;
        SEL_IO_BASE:   st.loadBase[1]  = 1'b1;
        SEL_IO_RANGE:  st.loadRange[1] = 1'b1;
        SEL_IO_REMAP:  st.loadRemap[1] = 1'b1;
        SEL_MODE:      st.loadMode     = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/lpci_win_datapath.sv
module lpci_win_datapath
  import lpci_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hit,
  output logic [1:0]        space,
  output logic [ADDR_W-1:0] pciAddr
);
  localparam int MODE_W = 3;

  logic [ADDR_W-1:0] baseReg  [NWIN];
  logic [ADDR_W-1:0] rangeReg [NWIN];
  logic [ADDR_W-1:0] remapReg [NWIN];
  logic [ADDR_W-1:0] xlat     [NWIN];
  logic [NWIN-1:0]   match;
  logic [MODE_W-1:0] modeReg;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (st.loadMode) modeReg <= cfgData[MODE_W-1:0];
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseReg[w]  <= '0;
        rangeReg[w] <= '0;
        remapReg[w] <= '0;
      end else begin
        if (st.loadBase[w])  baseReg[w]  <= cfgData;
        if (st.loadRange[w]) rangeReg[w] <= cfgData;
        if (st.loadRemap[w]) remapReg[w] <= cfgData;
      end
    end
    assign match[w] = modeReg[w] && (((reqAddr ^ baseReg[w]) & rangeReg[w]) == '0);
    assign xlat[w]  = (remapReg[w] & rangeReg[w]) | (reqAddr & ~rangeReg[w]);
  end

  space_e            nxtSpace;
  logic [ADDR_W-1:0] nxtAddr;

  always_comb begin
    nxtSpace = SP_NONE;
    nxtAddr  = '0;
    if (st.capture) begin
      if (match[0]) begin
        nxtSpace = SP_MEM;
        nxtAddr  = xlat[0];
      end else if (match[1]) begin
        nxtSpace = modeReg[2] ? SP_CFG : SP_IO;
        nxtAddr  = xlat[1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit     <= 1'b0;
      space   <= SP_NONE;
      pciAddr <= '0;
    end else begin
      hit     <= (nxtSpace != SP_NONE);
      space   <= nxtSpace;
      pciAddr <= nxtAddr;
    end
  end
endmodule

// File: rtl/lpci_window_decoder.sv
module lpci_window_decoder
  import lpci_win_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              hit,
  output logic [1:0]        space,
  output logic [ADDR_W-1:0] pciAddr
);
  strobes_t st;

  lpci_win_control u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .reqValid(reqValid),
    .st      (st)
  );

  lpci_win_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .cfgData(cfgData),
    .reqAddr(reqAddr),
    .hit    (hit),
    .space  (space),
    .pciAddr(pciAddr)
  );
endmodule

// File: rtl/lpci_window_decoder_chk.sv
module lpci_window_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              hit,
  input logic [1:0]        space,
  input logic [ADDR_W-1:0] pciAddr
);
  // R7: an idle cycle leaves no decode result behind
  p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !hit);

  // R7: a miss drives a clean, zero result
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (space == 2'b00 && pciAddr == '0));

  // R2: every hit names a PCI space
  p_hit_space_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> space != 2'b00);

  // R8: a hit is always caused by a request one cycle earlier
  p_hit_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hit) |-> $past(reqValid));
endmodule

bind lpci_window_decoder lpci_window_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .hit(hit), .space(space), .pciAddr(pciAddr)
);

// File: tb/lpci_window_decoder_test.sv
module lpci_window_decoder_test;
  localparam int AW = 32;
  localparam int NV = 10;

  logic          clk = 0;
  logic          rstN = 0;
  logic          cfgWrEn = 0;
  logic [2:0]    cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic          reqValid = 0;
  logic [AW-1:0] reqAddr = '0;
  logic          hit;
  logic [1:0]    space;
  logic [AW-1:0] pciAddr;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lpci_window_decoder #(.ADDR_W(AW)) uut (.*);

  // vector layout: {mode[2:0], addr[31:0], hit, space[1:0], pciAddr[31:0]}
  localparam logic [69:0] VECS [NV] = '{
    {3'd3, 32'h4000_0010, 1'b1, 2'b01, 32'h8000_0010},  // R2 low end
    {3'd3, 32'h400F_FFFC, 1'b1, 2'b01, 32'h800F_FFFC},  // R2 high end
    {3'd3, 32'h4010_0000, 1'b0, 2'b00, 32'h0},          // R7 just past window
    {3'd3, 32'h4008_1234, 1'b1, 2'b01, 32'h8008_1234},  // R6 overlap
    {3'd2, 32'h4008_1234, 1'b1, 2'b10, 32'h1234_1234},  // R3
    {3'd6, 32'h4008_ABCD, 1'b1, 2'b11, 32'h1234_ABCD},  // R4
    {3'd2, 32'h4009_0000, 1'b0, 2'b00, 32'h0},          // R7
    {3'd1, 32'h3FFF_FFFC, 1'b0, 2'b00, 32'h0},          // R7 below base
    {3'd0, 32'h4000_0010, 1'b0, 2'b00, 32'h0},          // R9 both disabled
    {3'd2, 32'h4008_FFFF, 1'b1, 2'b10, 32'h1234_FFFF}   // R3 top of io
  };

  task automatic check(string tag, logic eh, logic [1:0] es, logic [AW-1:0] ea);
    nRun++;
    if (hit !== eh || space !== es || pciAddr !== ea) begin
      nFail++;
      $display("FAIL %s: got hit=%0b space=%0b addr=%h, expected hit=%0b space=%0b addr=%h",
               tag, hit, space, pciAddr, eh, es, ea);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [AW-1:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic req(logic [AW-1:0] a);
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset outputs", 0, 2'b00, '0);
    req(32'h0000_0000);
    check("R1 windows disabled after reset", 0, 2'b00, '0);

    wr(3'd0, 32'h4000_0000);
    wr(3'd1, 32'hFFF0_0000);
    wr(3'd2, 32'h8000_0000);
    wr(3'd3, 32'h4008_0000);
    wr(3'd4, 32'hFFFF_0000);
    wr(3'd5, 32'h1234_0000);

    for (int i = 0; i < NV; i++) begin
      wr(3'd6, {29'd0, VECS[i][69:67]});
      req(VECS[i][66:35]);
      check($sformatf("R2/R3/R4/R6/R7 vector %0d", i), VECS[i][34], VECS[i][33:32], VECS[i][31:0]);
    end

    // R7: output clears after an idle cycle
    wr(3'd6, 32'd3);
    req(32'h4000_0010);
    @(negedge clk);
    check("R7 idle cycle clears", 0, 2'b00, '0);

    // R9: select code 7 writes nothing
    wr(3'd7, 32'h0000_0000);
    req(32'h4000_0020);
    check("R9 code 7 ignored", 1, 2'b01, 32'h8000_0020);

    // R8: write and request in the same cycle use the old remap
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 3'd2; cfgData = 32'h9000_0000;
    reqValid = 1; reqAddr = 32'h4000_0040;
    @(negedge clk);
    cfgWrEn = 0; reqValid = 0;
    check("R8 same-cycle write uses old value", 1, 2'b01, 32'h8000_0040);
    req(32'h4000_0040);
    check("R8 write applies next cycle", 1, 2'b01, 32'h9000_0040);

    // R5: narrower range mask
    wr(3'd1, 32'hFFFF_F000);
    req(32'h4000_0FF0);
    check("R5 masked-out bit keeps hit", 1, 2'b01, 32'h9000_0FF0);
    req(32'h4000_1010);
    check("R5 compared bit loses hit", 0, 2'b00, '0);

    // R1: reset again clears registers
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    check("R1 reset clears output", 0, 2'b00, '0);
    req(32'h4000_0010);
    check("R1 reset disables windows", 0, 2'b00, '0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule